// File: doc/BRIEF.md
# Three-Axis Sample Status Register Bank

This block holds the most recent signed 16-bit sample for each of three sensor axes and presents them, with a status byte and an identification byte, to a host through a byte-wide read port. Each axis has a ready flag that says a fresh sample is waiting and an overwrite flag that says a sample was replaced before the host fetched it. Two summary flags cover all enabled axes together. Reading an axis's high byte is what acknowledges it: the flags clear as a side effect of that read.

The host loads a read pointer with a start address and issues read strobes. Each strobe returns one byte on the following cycle and advances the pointer. In fast mode the pointer steps over the low-byte addresses, so a burst yields only the high bytes. Reading a high byte also copies the matching low byte into a shadow register, so a later low-byte read returns the half that belongs to the same sample. The sample side offers one pulse per axis and a channel-enable mask; the serial bus framing and the analog front end sit outside this block.

Top module: `sens_stat_regs`

## Requirements
- R1: After reset every flag and stored byte is zero and `rd_data` is 0x00. The status byte at address 0x00 carries X ready in bit 0, Y ready in bit 1, Z ready in bit 2, any-axis ready in bit 3, X overwrite in bit 4, Y overwrite in bit 5, Z overwrite in bit 6 and any-axis overwrite in bit 7.
- R2: A pulse on `smp_valid[i]` while `chan_en[i]` is 1 stores that axis's slice of `smp_data` (X in bits 15:0, Y in 31:16, Z in 47:32). The high byte reads at address 1+2i and the low byte at 2+2i (X 0x01/0x02, Y 0x03/0x04, Z 0x05/0x06). A pulse on a disabled axis is ignored: neither the sample nor any flag changes.
- R3: An axis's ready flag sets on an accepted sample and clears on a read of its high byte. When both happen in the same cycle, the flag stays set.
- R4: An axis's overwrite flag sets when a sample is accepted while its ready flag is set and its high byte is not being read in that cycle. It clears on a read of that high byte.
- R5: The any-axis ready flag sets on any accepted sample. The any-axis overwrite flag sets with any per-axis overwrite. Both clear only on the high-byte read that completes the reading of every enabled axis since the latest accepted sample; a new accepted sample re-arms all enabled axes.
- R6: A high-byte read copies that axis's current low byte into a shadow register. A low-byte read returns the shadow, even when a new sample has arrived since.
- R7: Address 0x07 always reads 0xC4.
- R8: A strobe reads the byte at `rd_addr` when `rd_start` is high in the same cycle, otherwise at the pointer. The byte appears on `rd_data` on the next cycle and holds until the next strobe. The pointer then moves to the next address, with 0x07 followed by 0x00.
- R9: With `fast_mode` high, a strobe at a high-byte address (0x01, 0x03, 0x05) advances the pointer by two, so the burst 0x00, 0x01, 0x03, 0x05, 0x07, 0x00 skips every low byte.
- R10: Addresses above 0x07 read 0x00, and the pointer moves from any of them to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 3 | New-sample pulse per axis (bit 0 X, 1 Y, 2 Z) |
| smp_data | input | 48 | Sample values, X in 15:0, Y in 31:16, Z in 47:32 |
| chan_en | input | 3 | Axis enable mask |
| fast_mode | input | 1 | Burst skips low-byte addresses |
| rd_start | input | 1 | Load the read pointer from rd_addr |
| rd_addr | input | 8 | Start address |
| rd_stb | input | 1 | Read one byte and advance the pointer |
| rd_data | output | 8 | Byte returned by the last strobe |

## Verification
Every result is due exactly one clock edge after its stimulus. A strobe's byte is on `rd_data` after that edge, and a sample pulse or side-effect read is visible in a status read issued the following cycle. The bench drives each stimulus on a falling edge and compares on the next falling edge against a reference computed from the pre-edge reference state. Because of this, same-cycle collisions such as a high-byte read meeting a new sample are judged by the rule stated in R3, R4 and R6, not by sampling order.

// File: rtl/sens_pkg.sv
package sens_pkg;

    localparam int NAXES  = 3;
    localparam int BYTE_W = 8;
    localparam int SMP_W  = 16;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_STAT = '0;
    localparam logic [ADDR_W-1:0] ADDR_ID   = ADDR_W'(2 * NAXES + 1);
    localparam logic [BYTE_W-1:0] ID_CODE   = 8'hC4;

    typedef struct packed {
        logic             any_ow;
        logic [NAXES-1:0] ow;
        logic             any_rdy;
        logic [NAXES-1:0] rdy;
    } stat_t;

    typedef enum logic [2:0] {
        SEL_STAT,
        SEL_HI,
        SEL_LO,
        SEL_ID,
        SEL_NONE
    } sel_e;

    function automatic logic [ADDR_W-1:0] hi_addr(input int axis);
        return ADDR_W'(2 * axis + 1);
    endfunction

    function automatic logic [ADDR_W-1:0] lo_addr(input int axis);
        return ADDR_W'(2 * axis + 2);
    endfunction

    function automatic sel_e decode(input logic [ADDR_W-1:0] a);
        if (a == ADDR_STAT) return SEL_STAT;
        if (a == ADDR_ID)   return SEL_ID;
        if (a > ADDR_ID)    return SEL_NONE;
        return a[0] ? SEL_HI : SEL_LO;
    endfunction

    function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                    input logic fast);
        if (a >= ADDR_ID) return ADDR_STAT;
        if (fast && a[0]) return a + ADDR_W'(2);
        return a + ADDR_W'(1);
    endfunction

endpackage

// File: rtl/sens_axis_slot.sv
module sens_axis_slot
    import sens_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             new_smp,
    input  logic             hi_rd,
    input  logic [SMP_W-1:0] smp_in,
    output logic [SMP_W-1:0] smp_q,
    output logic [BYTE_W-1:0] shadow_q,
    output logic             rdy_q,
    output logic             ow_q,
    output logic             ow_set
);

    logic rdy_n;
    logic ow_n;

    always_comb begin
        ow_set = new_smp & rdy_q & ~hi_rd;
        rdy_n  = new_smp | (rdy_q & ~hi_rd);
        ow_n   = ow_set | (ow_q & ~hi_rd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q    <= '0;
            shadow_q <= '0;
            rdy_q    <= 1'b0;
            ow_q     <= 1'b0;
        end else begin
            rdy_q <= rdy_n;
            ow_q  <= ow_n;
            if (hi_rd)   shadow_q <= smp_q[BYTE_W-1:0];
            if (new_smp) smp_q    <= smp_in;
        end
    end

endmodule

// File: rtl/sens_combined.sv
module sens_combined
    import sens_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NAXES-1:0] new_en,
    input  logic [NAXES-1:0] ow_set,
    input  logic [NAXES-1:0] hi_rd,
    input  logic [NAXES-1:0] chan_en,
    output logic             any_rdy_q,
    output logic             any_ow_q
);

    logic [NAXES-1:0] todo_q;
    logic [NAXES-1:0] todo_n;
    logic             all_read;

    always_comb begin
        todo_n   = (|new_en) ? chan_en : (todo_q & ~hi_rd);
        all_read = (|hi_rd) && ((todo_n & chan_en) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            todo_q    <= '0;
            any_rdy_q <= 1'b0;
            any_ow_q  <= 1'b0;
        end else begin
            todo_q    <= todo_n;
            any_rdy_q <= (|new_en) | (any_rdy_q & ~all_read);
            any_ow_q  <= (|ow_set) | (any_ow_q & ~all_read);
        end
    end

endmodule

// File: rtl/sens_rd_port.sv
module sens_rd_port
    import sens_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_start,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    rd_stb,
    input  logic                    fast_mode,
    input  stat_t                   stat,
    input  logic [NAXES*BYTE_W-1:0] hi_bytes,
    input  logic [NAXES*BYTE_W-1:0] lo_bytes,
    output logic [NAXES-1:0]        hi_rd,
    output logic [BYTE_W-1:0]       rd_data
);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] cur;
    logic [BYTE_W-1:0] byte_sel;
    sel_e              sel;

    always_comb begin
        cur = rd_start ? rd_addr : ptr_q;
        sel = decode(cur);
        for (int i = 0; i < NAXES; i++) begin
            hi_rd[i] = rd_stb && (cur == hi_addr(i));
        end
    end

    always_comb begin
        byte_sel = '0;
        unique case (sel)
            SEL_STAT: byte_sel = stat;
            SEL_ID:   byte_sel = ID_CODE;
            SEL_HI: begin
                for (int i = 0; i < NAXES; i++) begin
                    if (cur == hi_addr(i)) byte_sel = hi_bytes[i*BYTE_W +: BYTE_W];
                end
            end
            SEL_LO: begin
                for (int i = 0; i < NAXES; i++) begin
                    if (cur == lo_addr(i)) byte_sel = lo_bytes[i*BYTE_W +: BYTE_W];
                end
            end
            default:  byte_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= ADDR_STAT;
            rd_data <= '0;
        end else if (rd_stb) begin
            rd_data <= byte_sel;
            ptr_q   <= next_addr(cur, fast_mode);
        end else if (rd_start) begin
            ptr_q   <= rd_addr;
        end
    end

endmodule

// File: rtl/sens_stat_regs.sv
module sens_stat_regs
    import sens_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NAXES-1:0]       smp_valid,
    input  logic [NAXES*SMP_W-1:0] smp_data,
    input  logic [NAXES-1:0]       chan_en,
    input  logic                   fast_mode,
    input  logic                   rd_start,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic                   rd_stb,
    output logic [BYTE_W-1:0]      rd_data
);

    logic [NAXES-1:0]        new_en;
    logic [NAXES-1:0]        hi_rd;
    logic [NAXES-1:0]        rdy_q;
    logic [NAXES-1:0]        ow_q;
    logic [NAXES-1:0]        ow_set;
    logic                    any_rdy_q;
    logic                    any_ow_q;
    logic [NAXES*BYTE_W-1:0] hi_bytes;
    logic [NAXES*BYTE_W-1:0] lo_bytes;
    stat_t                   stat;

    assign new_en = smp_valid & chan_en;

    for (genvar g = 0; g < NAXES; g++) begin : g_axis
        logic [SMP_W-1:0] smp_q;
        sens_axis_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .new_smp  (new_en[g]),
            .hi_rd    (hi_rd[g]),
            .smp_in   (smp_data[g*SMP_W +: SMP_W]),
            .smp_q    (smp_q),
            .shadow_q (lo_bytes[g*BYTE_W +: BYTE_W]),
            .rdy_q    (rdy_q[g]),
            .ow_q     (ow_q[g]),
            .ow_set   (ow_set[g])
        );
        assign hi_bytes[g*BYTE_W +: BYTE_W] = smp_q[SMP_W-1 -: BYTE_W];
    end

    sens_combined u_comb (
        .clk       (clk),
        .rst       (rst),
        .new_en    (new_en),
        .ow_set    (ow_set),
        .hi_rd     (hi_rd),
        .chan_en   (chan_en),
        .any_rdy_q (any_rdy_q),
        .any_ow_q  (any_ow_q)
    );

    always_comb begin
        stat.any_ow  = any_ow_q;
        stat.ow      = ow_q;
        stat.any_rdy = any_rdy_q;
        stat.rdy     = rdy_q;
    end

    sens_rd_port u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_start  (rd_start),
        .rd_addr   (rd_addr),
        .rd_stb    (rd_stb),
        .fast_mode (fast_mode),
        .stat      (stat),
        .hi_bytes  (hi_bytes),
        .lo_bytes  (lo_bytes),
        .hi_rd     (hi_rd),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/sens_stat_chk.sv
module sens_stat_chk
    import sens_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NAXES-1:0]  smp_valid,
    input logic [NAXES-1:0]  chan_en,
    input logic              rd_start,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_stb,
    input logic [BYTE_W-1:0] rd_data,
    input logic [NAXES-1:0]  rdy,
    input logic [NAXES-1:0]  ow,
    input logic              any_rdy,
    input logic [NAXES-1:0]  hi_rd
);

    for (genvar g = 0; g < NAXES; g++) begin : g_ax
        AST_READY_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
            (smp_valid[g] && chan_en[g]) |=> rdy[g]); // R3
        AST_READY_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (hi_rd[g] && !(smp_valid[g] && chan_en[g])) |=> !rdy[g]); // R3
        AST_OVERWRITE_SET: assert property (@(posedge clk) disable iff (rst)
            (smp_valid[g] && chan_en[g] && rdy[g] && !hi_rd[g]) |=> ow[g]); // R4
        AST_OVERWRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
            hi_rd[g] |=> !ow[g]); // R4
        AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (rst)
            (!rdy[g] && !chan_en[g]) |=> !rdy[g]); // R2
    end

    AST_ANY_READY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(any_rdy) |-> $past(|(smp_valid & chan_en))); // R5
    AST_ID_CODE: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_start && rd_addr == ADDR_ID) |=> rd_data == ID_CODE); // R7
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_start && rd_addr > ADDR_ID) |=> rd_data == '0); // R10
    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data)); // R8

endmodule

bind sens_stat_regs sens_stat_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .chan_en   (chan_en),
    .rd_start  (rd_start),
    .rd_addr   (rd_addr),
    .rd_stb    (rd_stb),
    .rd_data   (rd_data),
    .rdy       (rdy_q),
    .ow        (ow_q),
    .any_rdy   (any_rdy_q),
    .hi_rd     (hi_rd)
);

// File: tb/tb_sens_stat_regs.sv
`timescale 1ns/1ps
module tb_sens_stat_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  smp_valid = '0;
    logic [47:0] smp_data = '0;
    logic [2:0]  chan_en = '0;
    logic        fast_mode = 1'b0;
    logic        rd_start = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic        rd_stb = 1'b0;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic [15:0] m_smp [3];
    logic [7:0]  m_sh  [3];
    logic [2:0]  m_rdy, m_ow, m_todo;
    logic        m_ardy, m_aow;
    logic [7:0]  m_ptr;
    int          seed = 0;

    sens_stat_regs dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .chan_en(chan_en), .fast_mode(fast_mode), .rd_start(rd_start),
        .rd_addr(rd_addr), .rd_stb(rd_stb), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    initial begin
        #3000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_byte(input logic [7:0] a);
        if (a == 8'h00) return {m_aow, m_ow, m_ardy, m_rdy};
        if (a == 8'h07) return 8'hC4;
        if (a > 8'h07)  return 8'h00;
        if (a[0])       return m_smp[(a - 1) >> 1][15:8];
        return m_sh[(a - 2) >> 1];
    endfunction

    function automatic string tag_of(input logic [7:0] a, input string extra);
        string t;
        if (a == 8'h00)      t = "R1 R3 R4 R5 status";
        else if (a == 8'h07) t = "R7 id";
        else if (a > 8'h07)  t = "R10 unmapped";
        else if (a[0])       t = "R2 high byte";
        else                 t = "R6 low byte";
        return {extra, " ", t, $sformatf(" addr=%02h", a)};
    endfunction

    // one clock: drive at falling edge, compare at next falling edge
    task automatic cyc(input logic [2:0] v, input logic rd, input logic st,
                       input logic [7:0] a, input string extra);
        logic [7:0] cur, exp;
        logic [2:0] hr, ne, ows, tn;
        logic       fin;
        seed++;
        for (int i = 0; i < 3; i++)
            smp_data[i*16 +: 16] = 16'(seed * 16'h01F3 + i * 16'h4B1 + 16'h8001);
        smp_valid = v; rd_stb = rd; rd_start = st; rd_addr = a;
        cur = st ? a : m_ptr;
        exp = ref_byte(cur);
        for (int i = 0; i < 3; i++) hr[i] = rd && (cur == 8'(2 * i + 1));
        ne  = v & chan_en;
        ows = ne & m_rdy & ~hr;
        tn  = (|ne) ? chan_en : (m_todo & ~hr);
        fin = (|hr) && ((tn & chan_en) == 3'b0);
        for (int i = 0; i < 3; i++) begin
            if (hr[i]) m_sh[i] = m_smp[i][7:0];
            if (ne[i]) m_smp[i] = smp_data[i*16 +: 16];
        end
        m_rdy  = ne | (m_rdy & ~hr);
        m_ow   = ows | (m_ow & ~hr);
        m_todo = tn;
        m_ardy = (|ne) | (m_ardy & ~fin);
        m_aow  = (|ows) | (m_aow & ~fin);
        if (rd) begin
            if (cur >= 8'h07)            m_ptr = 8'h00;
            else if (fast_mode && cur[0]) m_ptr = cur + 8'd2;
            else                          m_ptr = cur + 8'd1;
        end else if (st) m_ptr = a;
        @(posedge clk);
        @(negedge clk);
        if (rd) check(tag_of(cur, extra), rd_data, exp);
        smp_valid = '0; rd_stb = 1'b0; rd_start = 1'b0;
    endtask

    task automatic rd_at(input logic [7:0] a, input string extra);
        cyc(3'b000, 1'b1, 1'b1, a, extra);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin m_smp[i] = '0; m_sh[i] = '0; end
        m_rdy = '0; m_ow = '0; m_todo = '0; m_ardy = 0; m_aow = 0; m_ptr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset rd_data", rd_data, 8'h00);
        rd_at(8'h00, "R1 reset");
        rd_at(8'h07, "R7");

        // sweep every enable mask against every sample pattern
        for (int en = 0; en < 8; en++) begin
            for (int v = 1; v < 8; v++) begin
                chan_en = 3'(en);
                cyc(3'(v), 1'b0, 1'b0, 8'h00, "R2 R3 sample");
                rd_at(8'h00, "R3 after sample");
                cyc(3'(v), 1'b0, 1'b0, 8'h00, "R4 second sample");
                cyc(3'b000, 1'b0, 1'b1, 8'h00, "R8 load");
                for (int k = 0; k < 9; k++) cyc(3'b000, 1'b1, 1'b0, 8'h00, "R8 burst");
                rd_at(8'h00, "R5 after burst");
            end
        end

        // fast burst skips low bytes
        chan_en = 3'b111;
        cyc(3'b111, 1'b0, 1'b0, 8'h00, "R9 sample");
        fast_mode = 1'b1;
        rd_at(8'h00, "R9 fast");
        for (int k = 0; k < 5; k++) cyc(3'b000, 1'b1, 1'b0, 8'h00, "R9 fast");
        fast_mode = 1'b0;

        // coherent pair: low byte stays with the earlier high byte
        cyc(3'b001, 1'b0, 1'b0, 8'h00, "R6 sample");
        rd_at(8'h01, "R6 hi");
        cyc(3'b001, 1'b0, 1'b0, 8'h00, "R6 newer");
        rd_at(8'h02, "R6 shadow");

        // set wins against a same-cycle high-byte read
        cyc(3'b010, 1'b1, 1'b1, 8'h03, "R3 collide");
        rd_at(8'h00, "R3 set wins");
        rd_at(8'h03, "R3 clear");

        // combined flags wait for every enabled axis
        cyc(3'b001, 1'b0, 1'b0, 8'h00, "R5 sample");
        rd_at(8'h01, "R5 x");
        rd_at(8'h00, "R5 pending");
        rd_at(8'h03, "R5 y");
        rd_at(8'h00, "R5 pending");
        rd_at(8'h05, "R5 z");
        rd_at(8'h00, "R5 cleared");

        // unmapped and pointer recovery
        rd_at(8'h20, "R10");
        cyc(3'b000, 1'b1, 1'b0, 8'h00, "R10 wrap");
        rd_at(8'hFF, "R10");
        cyc(3'b000, 1'b1, 1'b0, 8'h00, "R10 wrap");

        // disabled-axis pulse leaves status untouched
        chan_en = 3'b010;
        cyc(3'b101, 1'b0, 1'b0, 8'h00, "R2 disabled");
        rd_at(8'h00, "R2 disabled");
        rd_at(8'h01, "R2 disabled");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule